// File: doc/BRIEF.md
# Board Control and Status Register Block

This block is a small memory-mapped peripheral for a development board. A simple 32-bit register bus (address, write strobe, write data, read strobe, read data) reaches five word-aligned registers inside a 64 KiB window. Two registers are fixed words: a build identifier and the processor clock rate in hertz. A third register drives the board LEDs and can be read back. A fourth reports the DIP switches, which are sampled through a two-flop synchronizer. The fifth register is a software reset trigger that accepts one magic value only.

A write of the magic word to the trigger register starts a reset-request state machine. It has two states. `RQ_IDLE` is the resting state. `RQ_FIRE` drives the request output high for exactly one clock cycle. The transition `RQ_IDLE -> RQ_FIRE` happens on a qualifying write. The transition `RQ_FIRE -> RQ_IDLE` always happens on the next edge. A qualifying write that lands while the machine is in `RQ_FIRE` is dropped, so the output never stays high for two cycles in a row. Read data is registered. The value appears one cycle after the read strobe and holds until the next read.

Top module: `board_ctl_regs`

## Requirements
- R1: A read at address 0x0000 returns the build identifier 0x09272011.
- R2: A read at address 0x0004 returns the clock rate 10,000,000 (0x00989680).
- R3: Address 0x0008 holds the LED register (bit = 1 means LED on). A write stores the low LED_W bits of the write data and drives `led_out`. A read returns that value zero-extended. The register is 0 after reset and changes only on a write to 0x0008. A read and a write to 0x0008 in the same cycle return the value from before the write.
- R4: A read at address 0x000C returns the DIP switch inputs (bit = 1 means switch on), zero-extended, after the inputs have passed through two synchronizing flops. A switch change is readable by a read strobe issued three clock edges after the change.
- R5: A write of exactly 0x0000DEAD to address 0x0010 asserts `board_rst_req` in the cycle after the write edge. A write of any other value to 0x0010 leaves `board_rst_req` low.
- R6: `board_rst_req` is high for exactly one cycle. A magic write accepted while it is high is ignored. After reset the request is low.
- R7: A read of any address other than 0x0000, 0x0004, 0x0008 or 0x000C returns 0. This includes 0x0010 and addresses that are not word-aligned. Writes to 0x0000, 0x0004, 0x000C and to unmapped addresses change no output and no readable value.
- R8: `bus_rdata` is 0 after reset, updates only on the edge where `bus_rd` is high, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Byte address within the window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| sw_in | input | 8 | Asynchronous DIP switch inputs |
| led_out | output | 8 | LED drive, 1 = on |
| board_rst_req | output | 1 | One-cycle board reset request |

## Verification
The bench writes values near the magic word, such as 0xDEAC, 0x1DEAD and 0xDEAD0000, to the trigger register. A decoder that compares only part of the data would raise a reset on one of them. It sends two magic writes back to back. A state machine that re-enters the firing state would stretch the pulse to two cycles. It writes to the read-only and unmapped addresses and reads unaligned addresses. A loose decoder would corrupt the LED value or return nonzero data for these. It also reads the LED register in the same cycle as a write, and reads the switches right after they change. These cases catch read-after-write mistakes and a synchronizer with the wrong number of stages.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
    localparam logic [31:0] OFS_BUILD = 32'h0000_0000;
    localparam logic [31:0] OFS_CLOCK = 32'h0000_0004;
    localparam logic [31:0] OFS_LIGHT = 32'h0000_0008;
    localparam logic [31:0] OFS_DIPSW = 32'h0000_000C;
    localparam logic [31:0] OFS_RESET = 32'h0000_0010;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_BUILD,
        SEL_CLOCK,
        SEL_LIGHT,
        SEL_DIPSW,
        SEL_RESET
    } reg_sel_e;

    typedef enum logic {
        RQ_IDLE,
        RQ_FIRE
    } rq_state_e;
endpackage

// File: rtl/bcr_sync.sv
module bcr_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= async_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/bcr_rstpulse.sv
module bcr_rstpulse (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic req
);
    import bcr_pkg::*;

    rq_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RQ_IDLE: if (trigger) st_d = RQ_FIRE;
            RQ_FIRE: st_d = RQ_IDLE;
            default: st_d = RQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RQ_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        req = 1'b0;
        unique case (st_q)
            RQ_IDLE: req = 1'b0;
            RQ_FIRE: req = 1'b1;
            default: req = 1'b0;
        endcase
    end

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req); // R6
    AST_FIRE_NEEDS_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> $past(trigger)); // R5
endmodule

// File: rtl/bcr_regfile.sv
module bcr_regfile #(
    parameter int          ADDR_W   = 16,
    parameter int          DATA_W   = 32,
    parameter int          LED_W    = 8,
    parameter int          SW_W     = 8,
    parameter logic [31:0] BUILD_ID = 32'h0927_2011,
    parameter logic [31:0] CLK_HZ   = 32'd10_000_000,
    parameter logic [31:0] MAGIC    = 32'h0000_DEAD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    input  logic [SW_W-1:0]   sw_sync,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [LED_W-1:0]  led_q,
    output logic              reset_hit
);
    import bcr_pkg::*;

    reg_sel_e          sel;
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        unique case (1'b1)
            (bus_addr == OFS_BUILD[ADDR_W-1:0]): sel = SEL_BUILD;
            (bus_addr == OFS_CLOCK[ADDR_W-1:0]): sel = SEL_CLOCK;
            (bus_addr == OFS_LIGHT[ADDR_W-1:0]): sel = SEL_LIGHT;
            (bus_addr == OFS_DIPSW[ADDR_W-1:0]): sel = SEL_DIPSW;
            (bus_addr == OFS_RESET[ADDR_W-1:0]): sel = SEL_RESET;
            default:                             sel = SEL_NONE;
        endcase
    end

    always_comb begin
        rd_mux = '0;
        unique case (sel)
            SEL_BUILD: rd_mux = DATA_W'(BUILD_ID);
            SEL_CLOCK: rd_mux = DATA_W'(CLK_HZ);
            SEL_LIGHT: rd_mux[LED_W-1:0] = led_q;
            SEL_DIPSW: rd_mux[SW_W-1:0]  = sw_sync;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                          led_q <= '0;
        else if (bus_wr && sel == SEL_LIGHT) led_q <= bus_wdata[LED_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    assign reset_hit = bus_wr && (sel == SEL_RESET) && (bus_wdata == DATA_W'(MAGIC));

    AST_LED_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == OFS_LIGHT[ADDR_W-1:0]) |=> $stable(led_q)); // R3
    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R8
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel inside {SEL_NONE, SEL_RESET}) |=> bus_rdata == '0); // R7
endmodule

// File: rtl/board_ctl_regs.sv
module board_ctl_regs #(
    parameter int          ADDR_W   = 16,
    parameter int          DATA_W   = 32,
    parameter int          LED_W    = 8,
    parameter int          SW_W     = 8,
    parameter int          SYNC_N   = 2,
    parameter logic [31:0] BUILD_ID = 32'h0927_2011,
    parameter logic [31:0] CLK_HZ   = 32'd10_000_000,
    parameter logic [31:0] MAGIC    = 32'h0000_DEAD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [SW_W-1:0]   sw_in,
    output logic [LED_W-1:0]  led_out,
    output logic              board_rst_req
);
    logic [SW_W-1:0] sw_sync;
    logic            reset_hit;

    bcr_sync #(.WIDTH(SW_W), .STAGES(SYNC_N)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sw_in),
        .sync_out (sw_sync)
    );

    bcr_regfile #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LED_W(LED_W), .SW_W(SW_W),
        .BUILD_ID(BUILD_ID), .CLK_HZ(CLK_HZ), .MAGIC(MAGIC)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .sw_sync   (sw_sync),
        .bus_rdata (bus_rdata),
        .led_q     (led_out),
        .reset_hit (reset_hit)
    );

    bcr_rstpulse u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .trigger (reset_hit),
        .req     (board_rst_req)
    );

    AST_REQ_FROM_MAGIC: assert property (@(posedge clk) disable iff (!rst_n)
        board_rst_req |-> $past(bus_wr && bus_addr == ADDR_W'(16'h0010)
                                && bus_wdata == DATA_W'(MAGIC))); // R5
endmodule

// File: tb/test_board_ctl_regs.sv
module test_board_ctl_regs;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] MAGIC = 32'h0000_DEAD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [7:0]  sw_in = '0;
    logic [7:0]  led_out;
    logic        board_rst_req;

    int checks = 0;
    int fails  = 0;
    logic [7:0] m_led = '0;
    logic [7:0] m_sw  = '0;
    logic       req_seen;

    always #(CLK_PERIOD/2) clk = ~clk;

    board_ctl_regs i_board_ctl_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .sw_in(sw_in), .led_out(led_out), .board_rst_req(board_rst_req)
    );

    function automatic logic [31:0] exp_read(input logic [15:0] a);
        case (a)
            16'h0000: return 32'h0927_2011;
            16'h0004: return 32'd10_000_000;
            16'h0008: return {24'h0, m_led};
            16'h000C: return {24'h0, m_sw};
            default:  return 32'h0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        req_seen = board_rst_req;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 16'h0008) m_led = d[7:0];
    endtask

    task automatic bus_read(input logic [15:0] a, input string tag);
        logic [31:0] e;
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        e = exp_read(a);
        @(posedge clk); #1;
        chk(bus_rdata == e, tag, bus_rdata, e);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        logic [31:0] hold;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        chk(led_out == 8'h00, "R3 reset led", {24'h0, led_out}, 32'h0);
        chk(board_rst_req == 1'b0, "R6 reset req", {31'h0, board_rst_req}, 32'h0);
        chk(bus_rdata == 32'h0, "R8 reset rdata", bus_rdata, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        bus_read(16'h0000, "R1 build id");
        bus_read(16'h0004, "R2 clock rate");
        bus_write(16'h0008, 32'hFFFF_FFA5);
        chk(led_out == 8'hA5, "R3 led drive", {24'h0, led_out}, 32'hA5);
        bus_read(16'h0008, "R3 led readback");

        // R3: read and write same cycle returns old value
        @(negedge clk);
        bus_addr = 16'h0008; bus_wr = 1'b1; bus_rd = 1'b1; bus_wdata = 32'h3C;
        @(posedge clk); #1;
        chk(bus_rdata == 32'hA5, "R3 read-during-write", bus_rdata, 32'hA5);
        @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b0; m_led = 8'h3C;
        chk(led_out == 8'h3C, "R3 led after rw", {24'h0, led_out}, 32'h3C);

        // R4: synchronizer depth
        @(negedge clk); sw_in = 8'h5A; m_sw = 8'h5A;
        @(posedge clk); @(posedge clk);
        bus_read(16'h000C, "R4 switches after sync");

        // R7: writes to read-only / unmapped have no effect
        bus_write(16'h0000, 32'hFFFF_FFFF);
        bus_write(16'h0004, 32'h1234_5678);
        bus_write(16'h000C, 32'hFF);
        bus_write(16'h0009, 32'hFF);
        bus_write(16'hFFFC, 32'hFF);
        chk(led_out == m_led, "R7 led untouched", {24'h0, led_out}, {24'h0, m_led});
        bus_read(16'h0000, "R7 build after write");
        bus_read(16'h0004, "R7 clock after write");
        bus_read(16'h000C, "R7 switches after write");
        bus_read(16'h0010, "R7 trigger reads zero");
        bus_read(16'h0002, "R7 unaligned zero");
        bus_read(16'h0014, "R7 unmapped zero");

        // R5: near-miss values
        foreach (hold[i]) begin end
        bus_write(16'h0010, 32'h0000_DEAC);
        chk(req_seen == 1'b0, "R5 DEAC no req", {31'h0, req_seen}, 32'h0);
        bus_write(16'h0010, 32'h0001_DEAD);
        chk(req_seen == 1'b0, "R5 1DEAD no req", {31'h0, req_seen}, 32'h0);
        bus_write(16'h0010, 32'hDEAD_0000);
        chk(req_seen == 1'b0, "R5 DEAD0000 no req", {31'h0, req_seen}, 32'h0);
        bus_write(16'h0014, MAGIC);
        chk(req_seen == 1'b0, "R5 magic wrong addr", {31'h0, req_seen}, 32'h0);
        bus_write(16'h0010, MAGIC);
        chk(req_seen == 1'b1, "R5 magic fires", {31'h0, req_seen}, 32'h1);
        @(posedge clk); #1;
        chk(board_rst_req == 1'b0, "R6 one cycle", {31'h0, board_rst_req}, 32'h0);

        // R6: back-to-back magic writes
        @(negedge clk);
        bus_addr = 16'h0010; bus_wdata = MAGIC; bus_wr = 1'b1;
        @(posedge clk); #1;
        chk(board_rst_req == 1'b1, "R6 first of pair", {31'h0, board_rst_req}, 32'h1);
        @(posedge clk); #1;
        chk(board_rst_req == 1'b0, "R6 second dropped", {31'h0, board_rst_req}, 32'h0);
        @(negedge clk); bus_wr = 1'b0;

        // R8: rdata holds without read strobe
        hold = bus_rdata;
        bus_write(16'h0008, 32'h77);
        repeat (3) @(posedge clk);
        #1;
        chk(bus_rdata == hold, "R8 rdata holds", bus_rdata, hold);

        // Random mix
        for (int n = 0; n < 300; n++) begin
            logic [15:0] a;
            logic [31:0] d;
            int pick;
            pick = int'($urandom_range(0, 6));
            case (pick)
                0: a = 16'h0000;
                1: a = 16'h0004;
                2: a = 16'h0008;
                3: a = 16'h000C;
                4: a = 16'h0010;
                default: a = 16'($urandom);
            endcase
            d = $urandom;
            if ($urandom_range(0, 1) == 0) begin
                bus_read(a, "R7 random read");
            end else begin
                bus_write(a, d);
                chk(req_seen == (a == 16'h0010 && d == MAGIC), "R5 random write req",
                    {31'h0, req_seen}, {31'h0, (a == 16'h0010 && d == MAGIC)});
                chk(led_out == m_led, "R3 random led", {24'h0, led_out}, {24'h0, m_led});
            end
            if (n % 50 == 0) begin
                @(negedge clk); sw_in = 8'($urandom); m_sw = sw_in;
                repeat (3) @(posedge clk);
                bus_read(16'h000C, "R4 random switches");
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule